// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a word-wide line memory with a write side and a read side that each run on their own clock. Each side has its own address counter. An active-low enable lets the counter advance and the access take place. An active-low synchronous reset sends the counter back to location zero. The storage has no full or empty detection and does no pointer comparison. Both counters wrap freely at the end of the array. The distance in words between what is written and what is read therefore comes only from when each side was last reset.

Typical uses are a fixed line delay in an image pipeline and a rate buffer between two clock domains. For a line delay, the write side is reset at the start of a line and the read side is reset N words later, which gives an N-word delay. The read data leaves through a register. A registered output-enable sits beside the data bus and stands in for a three-state driver.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH words of WIDTH bits (defaults 8192 and 8). Each location keeps its word until that location is written again.
- R2: On a write-clock rising edge with `wr_en_n` low, `wr_data` is stored at the write address and the write counter advances by one.
- R3: On a write-clock edge with `wr_en_n` high, nothing is stored and the write counter keeps its value.
- R4: On a write-clock edge with `wr_rst_n` low, the write counter goes to 0. If `wr_en_n` is also low, that edge writes location 0 and the counter then holds 1.
- R5: On a read-clock edge with `rd_en_n` low, `rd_data` takes the word at the read address, `rd_oe` goes to 1 and the read counter advances by one.
- R6: On a read-clock edge with `rd_en_n` high, the read counter holds, `rd_oe` goes to 0 and `rd_data` keeps its previous value.
- R7: On a read-clock edge with `rd_rst_n` low, the read counter goes to 0. If `rd_en_n` is also low, that edge reads location 0 and the counter then holds 1.
- R8: Each counter steps from DEPTH-1 back to 0 and keeps cycling.
- R9: A read and a write to the same location on the same edge return the word stored before that write.
- R10: If the write side is reset with enable low at edge k, the read side is reset with enable low at edge k+D (0 < D < DEPTH), and both stay enabled, then the read edge at k+D+j delivers the word written at edge k+j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write counter reset, active low, synchronous |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read counter reset, active low, synchronous |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | WIDTH | Registered read word |
| rd_oe | output | 1 | Registered output-enable, 1 while the bus would be driven |

## Verification
The bench builds the block with DEPTH of 64 and WIDTH of 8. At that depth, counter wrap-around and whole-frame overwrite take only a few hundred cycles. Both clocks come from one source. This makes same-edge collisions at a shared address happen on purpose when both sides are reset together. A fixed reset offset then shows the exact word delay, and random enable and reset patterns cover holding and priority.

// File: rtl/ldm_pkg.sv
// Package: shared defaults and the wrapping address step for the line memory.
// Assumes every address handed to ldm_next_addr is below the depth given.
package ldm_pkg;
    localparam int unsigned LDM_DEPTH_DEF = 8192;
    localparam int unsigned LDM_WIDTH_DEF = 8;

    // Next address with wrap from depth-1 to zero (depth need not be a power of two).
    function automatic int unsigned ldm_next_addr(input int unsigned cur, input int unsigned depth);
        return (cur == depth - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/ldm_addr_counter.sv
// Module: one port's address counter. An active-low enable lets it advance,
// and a synchronous active-low reset returns it to zero.
// The access address is the counter value, or zero while reset is low, so a
// reset edge with the enable low accesses location 0 and leaves the count at 1.
// Assumes DEPTH >= 2.
module ldm_addr_counter #(
    parameter int unsigned DEPTH  = ldm_pkg::LDM_DEPTH_DEF,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cnt
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // Address used by this edge: reset forces location zero.
    always_comb begin
        acc_addr = rst_n ? cnt : '0;
    end

    // Count update: step past the accessed location when enabled, else hold or clear.
    always_ff @(posedge clk) begin
        if (!en_n) begin
            cnt <= ADDR_W'(ldm_pkg::ldm_next_addr(int'(acc_addr), DEPTH));
        end else if (!rst_n) begin
            cnt <= '0;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |=> (cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1))); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(cnt)); // R3
endmodule

// File: rtl/ldm_sdp_ram.sv
// Module: storage array with one write port and one registered read port,
// each on its own clock. The read register updates only when read is asserted.
// A same-edge read of a location being written returns the old word.
// Assumes the two clocks are unrelated. No ordering between the ports is enforced.
module ldm_sdp_ram #(
    parameter int unsigned DEPTH  = ldm_pkg::LDM_DEPTH_DEF,
    parameter int unsigned WIDTH  = ldm_pkg::LDM_WIDTH_DEF,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // Write port: store the word when enabled.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port: register the addressed word when enabled, hold otherwise.
    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/line_delay_mem.sv
// Module: top of the dual-clock line delay memory. It ties one address counter
// to each port, the shared array, and the registered output-enable.
// Assumes callers set the delay by choosing when each side is reset; no
// full or empty state exists.
module line_delay_mem #(
    parameter int unsigned DEPTH = ldm_pkg::LDM_DEPTH_DEF,
    parameter int unsigned WIDTH = ldm_pkg::LDM_WIDTH_DEF
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe
);
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] w_acc, w_cnt, r_acc, r_cnt;

    ldm_addr_counter #(.DEPTH(DEPTH)) u_wr_cnt (
        .clk(wr_clk), .rst_n(wr_rst_n), .en_n(wr_en_n),
        .acc_addr(w_acc), .cnt(w_cnt)
    );

    ldm_addr_counter #(.DEPTH(DEPTH)) u_rd_cnt (
        .clk(rd_clk), .rst_n(rd_rst_n), .en_n(rd_en_n),
        .acc_addr(r_acc), .cnt(r_cnt)
    );

    ldm_sdp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .wclk(wr_clk), .we(!wr_en_n), .waddr(w_acc), .wdata(wr_data),
        .rclk(rd_clk), .re(!rd_en_n), .raddr(r_acc), .rdata(rd_data)
    );

    // Output-enable: registered on the read clock, high only after an enabled read.
    always_ff @(posedge rd_clk) begin
        rd_oe <= !rd_en_n;
    end

    AST_RD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_en_n |=> $stable(rd_data)); // R6

    AST_OE_RISE_SRC: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_oe) |-> $past(!rd_en_n)); // R5
endmodule

// File: tb/line_delay_mem_bench.sv
// Bench: behavioural model (int array, queue) compared on every clock.
module line_delay_mem_bench;
    localparam int DEPTH = 64;
    localparam int WIDTH = 8;
    localparam int DLY   = 5;

    logic clk = 1'b0;
    logic wr_rst_n = 1'b1, wr_en_n = 1'b1, rd_rst_n = 1'b1, rd_en_n = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic rd_oe;

    always #5 clk = ~clk;

    line_delay_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line_delay_mem (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int mem_m [DEPTH];
    bit valid_m [DEPTH];
    int wa = 0, ra = 0;
    int exp_d = 0;
    bit exp_known = 1'b0, exp_oe = 1'b0;
    string cur_req = "R6";

    task automatic check(string req, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // One clock: apply inputs, update the model at the edge, compare after it.
    task automatic cycle(bit wen_n, bit wrst_n, bit ren_n, bit rrst_n, int d);
        int idx;
        wr_en_n = wen_n; wr_rst_n = wrst_n; rd_en_n = ren_n; rd_rst_n = rrst_n;
        wr_data = WIDTH'(d);
        @(posedge clk);
        if (!ren_n) begin
            idx = rrst_n ? ra : 0;
            exp_known = valid_m[idx];
            exp_d = mem_m[idx];
            ra = (idx + 1) % DEPTH;
        end else if (!rrst_n) ra = 0;
        exp_oe = !ren_n;
        if (!wen_n) begin
            idx = wrst_n ? wa : 0;
            mem_m[idx] = d;
            valid_m[idx] = 1'b1;
            wa = (idx + 1) % DEPTH;
        end else if (!wrst_n) wa = 0;
        #2;
        check(cur_req, rd_oe == exp_oe, int'(rd_oe), int'(exp_oe));
        if (exp_known)
            check(cur_req, int'(rd_data) == exp_d, int'(rd_data), exp_d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int wlist[$];
        int ridx;
        // Reset state: both counters cleared, bus released (R6, R4, R7).
        cur_req = "R6";
        cycle(1, 0, 1, 0, 0);
        cycle(1, 0, 1, 0, 0);

        // Fixed offset delay: write reset with enable, read reset DLY edges later (R10, R2, R5, R4, R7).
        cur_req = "R10";
        ridx = 0;
        for (int t = 0; t < 3 * DEPTH; t++) begin
            int d;
            bit rd_on;
            d = (t * 37 + 11) & 8'hFF;
            rd_on = (t >= DLY);
            cycle(0, (t == 0) ? 1'b0 : 1'b1, !rd_on, (t == DLY) ? 1'b0 : 1'b1, d);
            wlist.push_back(d);
            if (rd_on) begin
                check("R10", int'(rd_data) == wlist[ridx], int'(rd_data), wlist[ridx]);
                ridx++;
            end
            if (t > DEPTH) cur_req = "R8";
        end

        // Hold on both sides, then resume without gaps (R3, R6).
        cur_req = "R3";
        for (int t = 0; t < 8; t++) cycle(1, 1, 1, 1, 8'hA5 ^ t);
        cur_req = "R1";
        for (int t = 0; t < DEPTH; t++) cycle(0, 1, 0, 1, (t * 13 + 3) & 8'hFF);

        // Both sides reset together: reads see the previous frame (R9).
        cur_req = "R9";
        cycle(0, 0, 0, 0, 8'h5A);
        for (int t = 1; t < DEPTH + 4; t++) cycle(0, 1, 0, 1, (t * 7 + 1) & 8'hFF);

        // Reset with enables high: counters clear without access (R4, R7).
        cur_req = "R4";
        cycle(1, 0, 1, 1, 8'h11);
        cur_req = "R7";
        cycle(1, 1, 1, 0, 8'h22);
        for (int t = 0; t < 6; t++) cycle(0, 1, 0, 1, 8'h30 + t);

        // Random enable and reset patterns against the model (R2, R3, R5, R6).
        cur_req = "R2";
        for (int t = 0; t < 2000; t++) begin
            cycle(($urandom % 3) == 0, ($urandom % 50) != 0,
                  ($urandom % 3) == 0, ($urandom % 50) != 0, $urandom & 8'hFF);
            if (t == 1000) cur_req = "R5";
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule